// File: doc/BRIEF.md
# Incremental Encoder Decoder with Triggered Position Capture

This block turns one axis of incremental position feedback into a 24-bit signed up/down count. The inputs are read only on cycles where the encoder-sample enable is high. A 4-bit mode code selects how the two feedback lines are read:

- as a pulse line plus a direction line, with either count sense;
- as a pair of x4 quadrature phases, with either count sense;
- as a pulse and direction pair taken from internal signals instead of the pins.

Alongside the counter, a capture unit copies the count into a holding register when a programmable trigger rises. The trigger is built from two sources:

- the index pulse, which can be inverted and can be gated to one quadrature state;
- one of four flag inputs, which can also be inverted.

The trigger uses either source alone or the AND of both. After a capture the unit stays disarmed until software reads the held position. A pending indication is raised for that whole interval.

Two state machines drive the block. The decoder tracks the last sampled phase pair in four states: QS_LL, QS_HL, QS_HH and QS_LH, named by the levels of A and B. Moving one step around the ring QS_LL -> QS_HL -> QS_HH -> QS_LH -> QS_LL is a FORWARD transition. Moving the other way is a REVERSE transition. Jumping to the opposite state is an ILLEGAL transition, and remaining in the same state is a HOLD. The capture unit has two states, CS_ARMED and CS_HELD. The TRIGGER transition goes from CS_ARMED to CS_HELD. The REARM transition goes from CS_HELD back to CS_ARMED on a read strobe.

Top module: `enc_capture_top`

## Requirements
- R1: After reset, count, capt_pos, capt_pending and quad_err are all zero, and the last sampled line pair is taken as A=0, B=0.
- R2: Mode 0: on a sample where the pulse line (enc_a) is 1 and was 0 at the previous sample, the count steps +1 if enc_b is 1 and -1 if enc_b is 0; cycles with samp_en low never change the count.
- R3: Mode 4 behaves as mode 0 with the step sign reversed.
- R4: Mode 8 behaves as mode 0 but takes pulse from int_pulse and direction from int_dir; enc_a and enc_b have no effect on the count.
- R5: Mode 3: each sampled move along 00 -> 10 -> 11 -> 01 -> 00 (written as A then B) counts +1, and each move the other way counts -1.
- R6: Mode 7 behaves as mode 3 with the step sign reversed.
- R7: In modes 3 and 7, a sample where A and B both differ from the previous sample leaves the count unchanged and sets quad_err, which stays set until reset.
- R8: Any mode code other than 0, 3, 4, 7 and 8 leaves the count unchanged.
- R9: The count wraps modulo 2^24 in both directions.
- R10: capt_ctrl bit 0 enables the index term, bit 1 enables the flag term, bit 2 inverts the index and bit 3 inverts the flag. With both bits 0 and 1 set, the trigger is the AND of the two terms; with neither set, no capture happens. A capture happens on a sample where the trigger is 1 and was 0 at the previous sample.
- R11: flag_sel picks the flag term: 0 home, 1 negative limit, 2 positive limit, 3 user.
- R12: With gate_idx_en set, the index term is 1 only while the sampled enc_a and enc_b are both 1 (gate_state 0) or both 0 (gate_state 1).
- R13: A capture raises capt_pending from the next cycle. While capt_pending is set, triggers are ignored and capt_pos holds. A capt_read pulse clears capt_pending on the next cycle and rearms the unit.
- R14: The captured value is the count as it stood before that same sample's count update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| samp_en | input | 1 | Encoder sample enable |
| mode | input | 4 | Decode mode code |
| enc_a | input | 1 | Phase A or pulse line |
| enc_b | input | 1 | Phase B or direction line |
| int_pulse | input | 1 | Internal pulse source |
| int_dir | input | 1 | Internal direction source |
| idx_in | input | 1 | Index pulse |
| flag_home | input | 1 | Home flag |
| flag_nlim | input | 1 | Negative limit flag |
| flag_plim | input | 1 | Positive limit flag |
| flag_user | input | 1 | User flag |
| capt_ctrl | input | 4 | Trigger composition and inversion |
| flag_sel | input | 2 | Flag choice |
| gate_idx_en | input | 1 | Gate index to one quadrature state |
| gate_state | input | 1 | 0 gates on high/high, 1 on low/low |
| capt_read | input | 1 | Read strobe for the held position |
| count | output | 24 | Position count |
| capt_pos | output | 24 | Captured position |
| capt_pending | output | 1 | Capture held, unit disarmed |
| quad_err | output | 1 | Sticky illegal-transition flag |

## Verification
A wrong phase-state register shows up at the next qualifying sample. The count takes a step of the wrong sign, misses a step, or quad_err sets without cause, and this is visible one clock after that sample. A wrong trigger history or a wrong capture state surfaces in the same way: capt_pending rises or clears one cycle early or late, or capt_pos holds a count taken on the wrong edge. The bench model is compared against every output on every clock, so any such divergence is reported in the cycle where it first appears.

// File: rtl/enc_cap_pkg.sv
package enc_cap_pkg;

    localparam logic [3:0] MODE_PD_CW  = 4'd0;
    localparam logic [3:0] MODE_QD_CW  = 4'd3;
    localparam logic [3:0] MODE_PD_CCW = 4'd4;
    localparam logic [3:0] MODE_QD_CCW = 4'd7;
    localparam logic [3:0] MODE_PD_INT = 4'd8;

    // Encoded as the position on the quadrature ring, so a difference
    // of 1 is a forward step, 3 a reverse step, 2 an illegal jump.
    typedef enum logic [1:0] {
        QS_LL = 2'd0,
        QS_HL = 2'd1,
        QS_HH = 2'd2,
        QS_LH = 2'd3
    } quad_st_e;

    typedef enum logic {
        CS_ARMED = 1'b0,
        CS_HELD  = 1'b1
    } capt_st_e;

    function automatic quad_st_e lines_to_state(input logic a, input logic b);
        unique case ({a, b})
            2'b00:   return QS_LL;
            2'b10:   return QS_HL;
            2'b11:   return QS_HH;
            default: return QS_LH;
        endcase
    endfunction

endpackage

// File: rtl/enc_decode.sv
module enc_decode
    import enc_cap_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             samp_en,
    input  logic [3:0]       mode,
    input  logic             enc_a,
    input  logic             enc_b,
    input  logic             int_pulse,
    input  logic             int_dir,
    output logic [CNT_W-1:0] count,
    output logic             quad_err
);

    quad_st_e st_q, st_d;
    logic     is_pd, is_quad, use_int, rev;
    logic     src_a, src_b, last_a;
    logic [1:0] pos_new, pos_old, delta;
    logic     step_up, step_dn, bad_step, pd_edge;

    // Mode decode
    always_comb begin
        is_pd   = 1'b0;
        is_quad = 1'b0;
        use_int = 1'b0;
        rev     = 1'b0;
        case (mode)
            MODE_PD_CW:  is_pd = 1'b1;
            MODE_PD_CCW: begin is_pd = 1'b1; rev = 1'b1; end
            MODE_QD_CW:  is_quad = 1'b1;
            MODE_QD_CCW: begin is_quad = 1'b1; rev = 1'b1; end
            MODE_PD_INT: begin is_pd = 1'b1; use_int = 1'b1; end
            default:     ;
        endcase
    end

    assign src_a = use_int ? int_pulse : enc_a;
    assign src_b = use_int ? int_dir   : enc_b;

    // Next-state process
    always_comb begin
        st_d = st_q;
        if (samp_en) st_d = lines_to_state(src_a, src_b);
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= QS_LL;
        else        st_q <= st_d;
    end

    // Output / step process
    always_comb begin
        pos_new  = st_d;
        pos_old  = st_q;
        delta    = pos_new - pos_old;
        last_a   = (st_q == QS_HL) || (st_q == QS_HH);
        pd_edge  = is_pd & samp_en & src_a & ~last_a;
        step_up  = 1'b0;
        step_dn  = 1'b0;
        bad_step = 1'b0;
        if (pd_edge) begin
            step_up = src_b ^ rev;
            step_dn = ~(src_b ^ rev);
        end else if (is_quad && samp_en) begin
            unique case (delta)
                2'd1: begin step_up = ~rev; step_dn = rev;  end
                2'd3: begin step_up = rev;  step_dn = ~rev; end
                2'd2: bad_step = 1'b1;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count    <= '0;
            quad_err <= 1'b0;
        end else begin
            if (step_up)      count <= count + 1'b1;
            else if (step_dn) count <= count - 1'b1;
            if (bad_step)     quad_err <= 1'b1;
        end
    end

endmodule

// File: rtl/capt_trigger.sv
module capt_trigger #(
    parameter int NFLAG = 4,
    localparam int SEL_W = $clog2(NFLAG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             samp_en,
    input  logic             idx_in,
    input  logic [NFLAG-1:0] flags,
    input  logic [SEL_W-1:0] flag_sel,
    input  logic [3:0]       ctrl,
    input  logic             gate_en,
    input  logic             gate_state,
    input  logic             enc_a,
    input  logic             enc_b,
    output logic             trig
);

    logic idx_pol, gate_hit, idx_term, flag_term, term, term_q;

    always_comb begin
        idx_pol   = idx_in ^ ctrl[2];
        gate_hit  = gate_state ? (~enc_a & ~enc_b) : (enc_a & enc_b);
        idx_term  = idx_pol & (~gate_en | gate_hit);
        flag_term = flags[flag_sel] ^ ctrl[3];
        unique case (ctrl[1:0])
            2'b01:   term = idx_term;
            2'b10:   term = flag_term;
            2'b11:   term = idx_term & flag_term;
            default: term = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       term_q <= 1'b0;
        else if (samp_en) term_q <= term;
    end

    assign trig = samp_en & term & ~term_q;

endmodule

// File: rtl/capt_latch.sv
module capt_latch
    import enc_cap_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig,
    input  logic             rd,
    input  logic [CNT_W-1:0] count_in,
    output logic [CNT_W-1:0] capt_pos,
    output logic             pending
);

    capt_st_e st_q, st_d;
    logic     load;

    // Next-state process
    always_comb begin
        st_d = st_q;
        load = 1'b0;
        unique case (st_q)
            CS_ARMED: if (trig) begin st_d = CS_HELD; load = 1'b1; end
            CS_HELD:  if (rd)   st_d = CS_ARMED;
            default:  st_d = CS_ARMED;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= CS_ARMED;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)    capt_pos <= '0;
        else if (load) capt_pos <= count_in;
    end

    // Output process
    always_comb pending = (st_q == CS_HELD);

endmodule

// File: rtl/enc_capture_top.sv
module enc_capture_top
    import enc_cap_pkg::*;
#(
    parameter int CNT_W = 24,
    parameter int NFLAG = 4,
    localparam int SEL_W = $clog2(NFLAG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             samp_en,
    input  logic [3:0]       mode,
    input  logic             enc_a,
    input  logic             enc_b,
    input  logic             int_pulse,
    input  logic             int_dir,
    input  logic             idx_in,
    input  logic             flag_home,
    input  logic             flag_nlim,
    input  logic             flag_plim,
    input  logic             flag_user,
    input  logic [3:0]       capt_ctrl,
    input  logic [SEL_W-1:0] flag_sel,
    input  logic             gate_idx_en,
    input  logic             gate_state,
    input  logic             capt_read,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] capt_pos,
    output logic             capt_pending,
    output logic             quad_err
);

    logic [NFLAG-1:0] flag_vec;
    logic             trig;

    always_comb begin
        flag_vec    = '0;
        flag_vec[0] = flag_home;
        flag_vec[1] = flag_nlim;
        flag_vec[2] = flag_plim;
        flag_vec[3] = flag_user;
    end

    enc_decode #(.CNT_W(CNT_W)) u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .samp_en   (samp_en),
        .mode      (mode),
        .enc_a     (enc_a),
        .enc_b     (enc_b),
        .int_pulse (int_pulse),
        .int_dir   (int_dir),
        .count     (count),
        .quad_err  (quad_err)
    );

    capt_trigger #(.NFLAG(NFLAG)) u_trg (
        .clk        (clk),
        .rst_n      (rst_n),
        .samp_en    (samp_en),
        .idx_in     (idx_in),
        .flags      (flag_vec),
        .flag_sel   (flag_sel),
        .ctrl       (capt_ctrl),
        .gate_en    (gate_idx_en),
        .gate_state (gate_state),
        .enc_a      (enc_a),
        .enc_b      (enc_b),
        .trig       (trig)
    );

    capt_latch #(.CNT_W(CNT_W)) u_lat (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig     (trig),
        .rd       (capt_read),
        .count_in (count),
        .capt_pos (capt_pos),
        .pending  (capt_pending)
    );

endmodule

// File: rtl/enc_capture_chk.sv
module enc_capture_chk #(
    parameter int CNT_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             samp_en,
    input logic [3:0]       capt_ctrl,
    input logic             capt_read,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] capt_pos,
    input logic             capt_pending,
    input logic             quad_err
);

    logic [CNT_W-1:0] prev_count;
    logic [CNT_W-1:0] diff;

    always_ff @(posedge clk) prev_count <= count;
    assign diff = count - prev_count;

    // R2 / R8: the count only moves on a sampled cycle
    a_r2_no_move_unsampled: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(samp_en) |-> count == $past(count));

    // R5 / R9: the count never moves by more than one step, wrap included
    a_r9_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (diff == '0) || (diff == CNT_W'(1)) || (diff == '1));

    // R7: the error flag is sticky
    a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $past(quad_err) |-> quad_err);

    // R13: held position is frozen while pending
    a_r13_hold_capt: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(capt_pending) && capt_pending) |-> capt_pos == $past(capt_pos));

    // R13: a read strobe while pending rearms on the next cycle
    a_r13_rearm: assert property (@(posedge clk) disable iff (!rst_n)
        (capt_pending && capt_read) |=> !capt_pending);

    // R10: a capture needs at least one trigger term enabled
    a_r10_needs_term: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(capt_pending) |-> $past(capt_ctrl[1:0]) != 2'b00);

endmodule

bind enc_capture_top enc_capture_chk #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .samp_en      (samp_en),
    .capt_ctrl    (capt_ctrl),
    .capt_read    (capt_read),
    .count        (count),
    .capt_pos     (capt_pos),
    .capt_pending (capt_pending),
    .quad_err     (quad_err)
);

// File: tb/sim_enc_capture_top.sv
module sim_enc_capture_top;

    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic samp_en = 1'b0;
    logic [3:0] mode = 4'd0;
    logic enc_a = 1'b0, enc_b = 1'b0, int_pulse = 1'b0, int_dir = 1'b0;
    logic idx_in = 1'b0;
    logic flag_home = 1'b0, flag_nlim = 1'b0, flag_plim = 1'b0, flag_user = 1'b0;
    logic [3:0] capt_ctrl = 4'd0;
    logic [1:0] flag_sel = 2'd0;
    logic gate_idx_en = 1'b0, gate_state = 1'b0, capt_read = 1'b0;
    logic [23:0] count, capt_pos;
    logic capt_pending, quad_err;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    string cur_req = "R1";

    // reference model state
    logic [23:0] m_cnt = '0, m_cap = '0;
    bit m_pend = 0, m_err = 0, m_la = 0, m_lb = 0, m_tl = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    enc_capture_top u0 (
        .clk(clk), .rst_n(rst_n), .samp_en(samp_en), .mode(mode),
        .enc_a(enc_a), .enc_b(enc_b), .int_pulse(int_pulse), .int_dir(int_dir),
        .idx_in(idx_in), .flag_home(flag_home), .flag_nlim(flag_nlim),
        .flag_plim(flag_plim), .flag_user(flag_user), .capt_ctrl(capt_ctrl),
        .flag_sel(flag_sel), .gate_idx_en(gate_idx_en), .gate_state(gate_state),
        .capt_read(capt_read), .count(count), .capt_pos(capt_pos),
        .capt_pending(capt_pending), .quad_err(quad_err)
    );

    function automatic int ring_pos(bit a, bit b);
        if (!a && !b) return 0;
        if (a && !b)  return 1;
        if (a && b)   return 2;
        return 3;
    endfunction

    task automatic model_step();
        bit idx, flg, term, sa, sb;
        int d;
        idx = idx_in ^ capt_ctrl[2];
        if (gate_idx_en)
            idx = idx && (gate_state ? (!enc_a && !enc_b) : (enc_a && enc_b));
        case (flag_sel)
            2'd0: flg = flag_home;
            2'd1: flg = flag_nlim;
            2'd2: flg = flag_plim;
            default: flg = flag_user;
        endcase
        flg = flg ^ capt_ctrl[3];
        term = (capt_ctrl[1:0] == 2'b01) ? idx :
               (capt_ctrl[1:0] == 2'b10) ? flg :
               (capt_ctrl[1:0] == 2'b11) ? (idx && flg) : 1'b0;
        if (m_pend) begin
            if (capt_read) m_pend = 0;
        end else if (samp_en && term && !m_tl) begin
            m_cap = m_cnt;
            m_pend = 1;
        end
        if (samp_en) begin
            m_tl = term;
            sa = (mode == 4'd8) ? int_pulse : enc_a;
            sb = (mode == 4'd8) ? int_dir : enc_b;
            if (mode == 4'd0 || mode == 4'd4 || mode == 4'd8) begin
                if (sa && !m_la) m_cnt = (sb ^ (mode == 4'd4)) ? m_cnt + 24'd1 : m_cnt - 24'd1;
            end else if (mode == 4'd3 || mode == 4'd7) begin
                d = (ring_pos(sa, sb) - ring_pos(m_la, m_lb) + 4) % 4;
                if (d == 1) m_cnt = (mode == 4'd3) ? m_cnt + 24'd1 : m_cnt - 24'd1;
                if (d == 3) m_cnt = (mode == 4'd3) ? m_cnt - 24'd1 : m_cnt + 24'd1;
                if (d == 2) m_err = 1;
            end
            m_la = sa;
            m_lb = sb;
        end
    endtask

    task automatic chk(string what, logic [23:0] act, logic [23:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
        end
    endtask

    task automatic compare_all();
        chk("count", count, m_cnt);
        chk("capt_pos", capt_pos, m_cap);
        chk("capt_pending", {23'd0, capt_pending}, {23'd0, m_pend});
        chk("quad_err", {23'd0, quad_err}, {23'd0, m_err});
    endtask

    task automatic tick(bit s);
        samp_en = s;
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare_all();
        capt_read = 1'b0;
    endtask

    task automatic ab(bit a, bit b);
        enc_a = a; enc_b = b; tick(1);
    endtask

    task automatic pd_pulse(bit dir);
        enc_b = dir; enc_a = 1'b1; tick(1);
        enc_a = 1'b0; tick(1);
    endtask

    task automatic do_read();
        capt_read = 1'b1; tick(0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        cur_req = "R1";
        compare_all();
        rst_n = 1'b1;
        tick(0);

        // R2: pulse and direction, clockwise sense
        cur_req = "R2"; mode = 4'd0;
        pd_pulse(1); pd_pulse(1); pd_pulse(1); pd_pulse(0);
        enc_a = 1'b1; tick(0); enc_a = 1'b0; tick(0);   // unsampled pulse
        enc_b = 1'b1; enc_a = 1'b1; tick(1); tick(1);   // held high, one step
        enc_a = 1'b0; tick(1);

        // R3: reversed sense
        cur_req = "R3"; mode = 4'd4;
        pd_pulse(1); pd_pulse(0); pd_pulse(0);

        // R4: internal source, pins ignored
        cur_req = "R4"; mode = 4'd8;
        int_dir = 1'b1;
        int_pulse = 1'b1; enc_a = 1'b1; enc_b = 1'b0; tick(1);
        int_pulse = 1'b0; enc_a = 1'b0; tick(1);
        enc_a = 1'b1; tick(1); enc_a = 1'b0; tick(1);
        int_dir = 1'b0; int_pulse = 1'b1; tick(1); int_pulse = 1'b0; tick(1);

        // R5: quadrature forward then back, through zero (R9 wrap)
        cur_req = "R5"; mode = 4'd3; enc_a = 1'b0; enc_b = 1'b0; tick(1);
        ab(1,0); ab(1,1); ab(0,1); ab(0,0); ab(1,0);
        ab(0,0); ab(0,1); ab(1,1);
        cur_req = "R9";
        repeat (2) begin ab(1,0); ab(0,0); ab(0,1); ab(1,1); end
        ab(0,1); ab(0,0); ab(1,0); ab(1,1); ab(0,1); ab(0,0);
        ab(1,0); ab(1,1); ab(0,1); ab(0,0);

        // R6: reversed quadrature
        cur_req = "R6"; mode = 4'd7;
        ab(1,0); ab(1,1); ab(0,1); ab(1,1);

        // R7: illegal jump, count held, sticky error
        cur_req = "R7";
        ab(0,0); ab(1,1); ab(1,0); ab(0,0);

        // R8: unsupported mode codes
        cur_req = "R8"; mode = 4'd5;
        ab(1,0); ab(1,1); ab(0,1); pd_pulse(1);
        mode = 4'd12; pd_pulse(1);

        // R10 / R14: index-only capture
        cur_req = "R10"; mode = 4'd3; enc_a = 1'b0; enc_b = 1'b0; tick(1);
        capt_ctrl = 4'b0001;
        ab(1,0); idx_in = 1'b1; ab(1,1);
        cur_req = "R14"; tick(1);
        // R13: second trigger ignored while pending, then read
        cur_req = "R13";
        idx_in = 1'b0; ab(0,1); idx_in = 1'b1; ab(0,0); tick(0);
        do_read(); tick(1);
        idx_in = 1'b0; ab(1,0); idx_in = 1'b1; ab(1,1); do_read();

        // R10: inverted index (falling idx_in triggers)
        cur_req = "R10"; capt_ctrl = 4'b0101;
        idx_in = 1'b1; tick(1); idx_in = 1'b0; ab(0,1); do_read();
        // neither term enabled
        capt_ctrl = 4'b0000; idx_in = 1'b1; ab(0,0); idx_in = 1'b0; tick(1);
        idx_in = 1'b1; tick(1);

        // R11: each flag selection
        cur_req = "R11"; capt_ctrl = 4'b0010; idx_in = 1'b0;
        for (int s = 0; s < 4; s++) begin
            flag_sel = 2'(s);
            flag_home = 1'b1; flag_nlim = 1'b1; flag_plim = 1'b1; flag_user = 1'b1;
            flag_home = (s != 0) ? 1'b0 : 1'b1;
            tick(1); ab(1,0);
            flag_home = 1'b0; flag_nlim = 1'b0; flag_plim = 1'b0; flag_user = 1'b0;
            tick(1);
            case (s)
                0: flag_home = 1'b1;
                1: flag_nlim = 1'b1;
                2: flag_plim = 1'b1;
                default: flag_user = 1'b1;
            endcase
            ab(0,0); tick(1); do_read();
        end
        flag_home = 1'b0; flag_nlim = 1'b0; flag_plim = 1'b0; flag_user = 1'b0;

        // R10: AND of index and inverted flag
        cur_req = "R10"; capt_ctrl = 4'b1011; flag_sel = 2'd1;
        flag_nlim = 1'b1; idx_in = 1'b1; ab(1,0); ab(1,1);
        flag_nlim = 1'b0; ab(0,1); do_read();
        idx_in = 1'b0; tick(1);

        // R12: gated index, high/high then low/low
        cur_req = "R12"; capt_ctrl = 4'b0001; gate_idx_en = 1'b1; gate_state = 1'b0;
        ab(0,0); idx_in = 1'b1; ab(1,0); ab(1,1); ab(0,1); do_read();
        ab(0,0); ab(1,0); idx_in = 1'b0; tick(1);
        gate_state = 1'b1; idx_in = 1'b1; ab(1,1); ab(0,1); ab(0,0); ab(0,1); do_read();
        idx_in = 1'b0; gate_idx_en = 1'b0; tick(1); tick(0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule